// File: doc/BRIEF.md
# Fall-through shift handshake FIFO

This block is a clocked first-in first-out store with a strobe-and-flag handshake on each side. A writer presents a word on `in_data` and raises `shift_in`. The word is taken on the clock edge that first sees the strobe high, and `in_ready` then drops. A stored word moves to `out_data` without any read request and is announced by `out_ready`. A reader takes it by holding `shift_out` high for at least one clock. When the store runs dry, the output keeps the last word it showed.

Back-pressure works through the two flags. A writer may raise `shift_in` only while `in_ready` is high. The flag stays low while the store is full, and after each accepted word it stays low until the strobe is seen low again. On the read side the word stays on `out_data` and `out_ready` stays high for as long as `shift_out` is held low. Because of these rules, several instances can be chained for depth: the `out_ready` and `out_data` of one stage drive the `shift_in` and `in_data` of the next, and the next stage's `in_ready` drives the previous stage's `shift_out`. The active-low `rst_n` clears the whole block.

Top module: `fallthru_fifo`

## Requirements
- R1: While `rst_n` is low, `out_data` is all zeros, `in_ready` is 1 and `out_ready` is 0.
- R2: A word is accepted at a clock edge where `shift_in` is 1, was 0 at the previous edge, and `in_ready` is 1. After that edge `in_ready` is 0, and it stays 0 until an edge sees `shift_in` at 0 with room in the store.
- R3: The block holds DEPTH queued words plus the one word at the output. Once that many words are held, `in_ready` stays 0. A `shift_in` pulse while `in_ready` is 0 stores nothing, and no extra word ever appears at the output.
- R4: A word written into an empty FIFO reaches `out_data` with `out_ready` at 1 and no action on `shift_out`. Words leave in the order they were written.
- R5: `out_data` changes only at an edge where `out_ready` was 0 before the edge and is 0 after it. `out_ready` rises one edge after the new word is in place, so whenever `out_ready` is 1 the data is stable.
- R6: A shown word is taken at the first edge at which `out_ready` is 1 and `shift_out` was 1 at the previous edge. `out_ready` falls at that edge, and `out_data` keeps the word until the next one is loaded.
- R7: While no word is waiting, `out_data` holds the last word shown until reset or until a new word arrives.
- R8: Suppose `shift_out` is held high while the FIFO is empty and a word is written. The word reaches `out_data`, `out_ready` is 1 for exactly one cycle, and the word stays on `out_data`. Further words wait and are not presented until `shift_out` is seen low.
- R9: If `shift_in` is 1 when `rst_n` rises, the word on `in_data` is stored at the first edge. `in_ready` is then 0 until `shift_in` goes to 0.
- R10: If `shift_in` is 0 when `rst_n` rises, `in_ready` is 1 and nothing is stored until `shift_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low clear |
| in_data | input | WIDTH | Word to store |
| shift_in | input | 1 | Write strobe; a rising level is one write |
| in_ready | output | 1 | High when a new write strobe may be given |
| out_data | output | WIDTH | Word at the head of the FIFO, or the last one shown |
| shift_out | input | 1 | Read strobe; takes the shown word |
| out_ready | output | 1 | High when `out_data` holds an untaken, stable word |

## Verification
Suppose the output stage takes a word twice, or loads while a word is still shown. The words on `out_data` would then come out of order or be skipped, and this shows at the very next read. A count that drifts in the store would make `in_ready` stay high past the capacity, or stay low too early, within one write. A stuck "wait for low strobe" flag would keep `out_ready` low forever once `shift_out` falls. The ordering of the flag against data changes is watched on every cycle, so an early flag is seen in the cycle it happens.

// File: rtl/fallthru_pkg.sv
package fallthru_pkg;
  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_SETTLE = 2'd1,
    OUT_SHOW   = 2'd2
  } out_state_e;
endpackage

// File: rtl/ft_store.sv
module ft_store #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nx, rd_nx;
  logic [CW-1:0]    count;

  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_nx = wr_ptr + AW'(1);
      assign rd_nx = rd_ptr + AW'(1);
    end else begin : g_wrap
      assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nx;
      if (pop)  rd_ptr <= rd_nx;
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: the write side never pushes into a full store
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R4: the output stage never pulls from an empty store
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/ft_in_port.sv
module ft_in_port (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_in,
  input  logic full,
  input  logic pop,
  output logic push,
  output logic in_ready
);
  logic si_q;

  assign push = shift_in && !si_q && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q     <= 1'b0;
      in_ready <= 1'b1;
    end else begin
      si_q     <= shift_in;
      in_ready <= !push && (shift_in ? in_ready : 1'b1) && !(full && !pop);
    end
  end

  // R2: an accepted write drops the ready flag
  p_ir_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !in_ready);

  // R9: a low ready flag stays low while the strobe is still high
  p_ir_wait_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && shift_in) |=> !in_ready);
endmodule

// File: rtl/ft_out_port.sv
module ft_out_port
  import fallthru_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_out,
  input  logic             have_word,
  input  logic [WIDTH-1:0] pop_data,
  output logic             pop,
  output logic [WIDTH-1:0] out_data,
  output logic             out_ready
);
  out_state_e state;
  logic       so_q;
  logic       spent;
  logic       take;

  assign take      = (state == OUT_SHOW) && so_q;
  assign pop       = (state == OUT_IDLE) && have_word && !spent;
  assign out_ready = (state == OUT_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= OUT_IDLE;
      so_q     <= 1'b0;
      spent    <= 1'b0;
      out_data <= '0;
    end else begin
      so_q <= shift_out;
      if (take)            spent <= shift_out;
      else if (!shift_out) spent <= 1'b0;
      case (state)
        OUT_IDLE: if (pop) begin
          out_data <= pop_data;
          state    <= OUT_SETTLE;
        end
        OUT_SETTLE: state <= OUT_SHOW;
        OUT_SHOW:   if (take) state <= OUT_IDLE;
        default:    state <= OUT_IDLE;
      endcase
    end
  end

  // R5: data changes only with the flag low on both sides of the edge
  p_data_under_low_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data != $past(out_data)) |-> (!out_ready && !$past(out_ready)));

  // R5: the flag rises on already-settled data
  p_flag_on_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> $stable(out_data));

  // R8: with the read strobe already high, the flag lasts one cycle
  p_flag_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && so_q) |=> !out_ready);

  // R7: without a load the last word is held
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !pop) |=> $stable(out_data));
endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_data,
  input  logic             shift_in,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  input  logic             shift_out,
  output logic             out_ready
);
  logic             push, pop, full, empty;
  logic [WIDTH-1:0] head;

  ft_in_port u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_in (shift_in),
    .full     (full),
    .pop      (pop),
    .push     (push),
    .in_ready (in_ready)
  );

  ft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (in_data),
    .pop       (pop),
    .pop_data  (head),
    .full      (full),
    .empty     (empty)
  );

  ft_out_port #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_out (shift_out),
    .have_word (!empty),
    .pop_data  (head),
    .pop       (pop),
    .out_data  (out_data),
    .out_ready (out_ready)
  );
endmodule

// File: tb/fallthru_fifo_tb_top.sv
module fallthru_fifo_tb_top;
  localparam int W = 4;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [W-1:0] in_data = '0;
  logic         shift_in = 1'b0;
  logic         shift_out = 1'b0;
  logic         in_ready, out_ready;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int r5_viol = 0;
  logic [W-1:0] q[$];

  always #5 clk = ~clk;

  fallthru_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .shift_in(shift_in),
    .in_ready(in_ready), .out_data(out_data), .shift_out(shift_out),
    .out_ready(out_ready)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R5 monitor: data may change only with the flag low now and before
  logic [W-1:0] prev_d;
  logic         prev_or;
  logic         prev_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_ok && (out_data != prev_d) && (out_ready || prev_or))
      r5_viol++;
    prev_d  <= out_data;
    prev_or <= out_ready;
    prev_ok <= rst_n;
  end

  task automatic wait_or(string req);
    int n = 0;
    while (!out_ready && n < 40) begin
      @(negedge clk);
      n++;
    end
    check_eq(req, "out_ready reached", int'(out_ready), 1);
  endtask

  task automatic do_write(logic [W-1:0] d, output logic ir_after);
    int n = 0;
    while (!in_ready && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!in_ready) check_eq("R2", "in_ready before write", 0, 1);
    in_data  = d;
    shift_in = 1'b1;
    @(negedge clk);
    ir_after = in_ready;
    shift_in = 1'b0;
    @(negedge clk);
    q.push_back(d);
  endtask

  task automatic do_read(string req);
    logic [W-1:0] exp;
    wait_or(req);
    exp = q.pop_front();
    check_eq(req, "word order", int'(out_data), int'(exp));
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
    @(negedge clk);
    check_eq("R6", "out_ready after take", int'(out_ready), 0);
    check_eq("R6", "word kept after take", int'(out_data), int'(exp));
  endtask

  task automatic t_reset_si_low();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1", "out_data in reset", int'(out_data), 0);
    check_eq("R1", "in_ready in reset", int'(in_ready), 1);
    check_eq("R1", "out_ready in reset", int'(out_ready), 0);
    rst_n = 1'b1;
    q.delete();
    repeat (4) @(negedge clk);
    check_eq("R10", "in_ready after release", int'(in_ready), 1);
    in_data = 4'h3;
    repeat (4) @(negedge clk);
    check_eq("R10", "nothing stored without strobe", int'(out_ready), 0);
  endtask

  task automatic t_order();
    logic ir;
    do_write(4'h6, ir);
    check_eq("R2", "in_ready low after accept", int'(ir), 0);
    check_eq("R2", "in_ready back after strobe low", int'(in_ready), 1);
    do_read("R4");
    for (int i = 0; i < 5; i++) do_write(W'(4'h9 ^ i), ir);
    for (int i = 0; i < 5; i++) do_read("R4");
    repeat (10) @(negedge clk);
    check_eq("R7", "flag low when empty", int'(out_ready), 0);
    check_eq("R7", "last word held", int'(out_data), int'(4'h9 ^ 4));
  endtask

  task automatic t_capacity();
    logic ir;
    for (int i = 0; i < D + 1; i++) do_write(W'(i + 1), ir);
    repeat (3) @(negedge clk);
    check_eq("R3", "in_ready low when full", int'(in_ready), 0);
    in_data  = 4'hF;
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R3", "in_ready still low", int'(in_ready), 0);
    for (int i = 0; i < D + 1; i++) do_read("R3");
    repeat (10) @(negedge clk);
    check_eq("R3", "no extra word", int'(out_ready), 0);
    check_eq("R3", "last kept word", int'(out_data), D + 1);
  endtask

  task automatic t_so_held();
    logic ir;
    int highs = 0;
    shift_out = 1'b1;
    repeat (2) @(negedge clk);
    do_write(4'hA, ir);
    for (int i = 0; i < 12; i++) begin
      if (out_ready) highs++;
      @(negedge clk);
    end
    void'(q.pop_front());
    check_eq("R8", "flag high cycles", highs, 1);
    check_eq("R8", "word stays", int'(out_data), 4'hA);
    do_write(4'hB, ir);
    do_write(4'hC, ir);
    repeat (10) @(negedge clk);
    check_eq("R8", "queued word not shown", int'(out_ready), 0);
    check_eq("R8", "first word still out", int'(out_data), 4'hA);
    shift_out = 1'b0;
    do_read("R8");
    do_read("R8");
  endtask

  task automatic t_reset_si_high();
    rst_n    = 1'b0;
    shift_in = 1'b1;
    in_data  = 4'h5;
    repeat (2) @(negedge clk);
    check_eq("R1", "out_data cleared", int'(out_data), 0);
    rst_n = 1'b1;
    q.delete();
    @(negedge clk);
    check_eq("R9", "in_ready low after release", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    check_eq("R9", "in_ready held low", int'(in_ready), 0);
    q.push_back(4'h5);
    wait_or("R9");
    check_eq("R9", "word written at release", int'(out_data), 4'h5);
    shift_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_eq("R9", "in_ready after strobe low", int'(in_ready), 1);
    do_read("R9");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    t_reset_si_low();
    t_order();
    t_capacity();
    t_so_held();
    t_reset_si_high();
    check_eq("R5", "flag/data ordering violations", r5_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule